// File: doc/BRIEF.md
# Per-Function-Type Issue Picker

This block decides which execution unit receives the instruction offered on its input. Each unit serves one or more function types, such as logical, shift or multiply work. For every function type the block keeps its own candidate set: the units that can perform that type and are not busy. Each set feeds its own fixed-priority picker. The requested type code selects which picker's result is used. When the input is valid and a suitable unit is idle, the chosen unit gets a single-cycle issue pulse.

`found_o` goes low when no idle unit can serve the requested type, and the instruction then stalls at the input. The units' busy flags rise one cycle after their issue pulse. To cover that gap, a per-unit selected output merges the pulse with the busy flag. Register-port access therefore stays granted from the issue cycle until the unit finishes.

Top module: `issue_picker`

## Requirements
- R1: `found_o` is high exactly when, out of reset, the type code is below NUM_TYPES and at least one unit able to serve that type has its busy bit low. With the default mapping, type 0 is served by units 0, 1 and 2, type 1 by units 2 and 3, and type 2 by units 4 and 5. Type code 3 is served by no unit.
- R2: `in_ready_o` always equals `found_o`.
- R3: `issue_o` has at most one bit set. Exactly one bit is set whenever `in_valid_i` and `found_o` are both high.
- R4: Among the idle units able to serve the requested type, the unit with the lowest index is issued.
- R5: An issued unit never has its busy bit high in the cycle it is issued, and it is always capable of the requested type.
- R6: `selected_o[u]` equals `issue_o[u]` OR `unit_busy_i[u]`. It is therefore high from the issue cycle through the whole busy period.
- R7: When `in_valid_i` is low, `issue_o` is all zero, and `found_o` still reports availability.
- R8: While `rst_n` is low, `found_o`, `in_ready_o` and `issue_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid_i | input | 1 | An instruction is offered |
| in_type_i | input | TYPE_W (2) | Function type code of the offered instruction |
| in_ready_o | output | 1 | Instruction accepted this cycle when valid |
| found_o | output | 1 | An idle unit of the requested type exists |
| unit_busy_i | input | NUM_UNITS (6) | Busy flag from each unit |
| issue_o | output | NUM_UNITS (6) | One-cycle issue pulse, one-hot |
| selected_o | output | NUM_UNITS (6) | Register-port grant per unit |

## Verification
A wrong candidate set or a wrong priority order shows up at `issue_o` in the same cycle the instruction is offered. A wrong decode of the type code does the same. Any of these faults issues to the wrong unit, or to a unit that is already busy. A stale or missing availability term appears at once as a mismatch on `found_o` and `in_ready_o`: the bench drives requests against units that have just become busy or just finished. A grant that drops the issue pulse is exposed in the issue cycle itself, before busy rises. A grant that drops the busy term is exposed on the following cycle.

// File: rtl/issue_pick_pkg.sv
package issue_pick_pkg;
  localparam int MAX_UNITS = 64;
  typedef logic [MAX_UNITS-1:0] unit_vec_t;

  // isolate the lowest set bit via two's complement
  function automatic unit_vec_t lowest_set(unit_vec_t v);
    return v & (~v + unit_vec_t'(1));
  endfunction

  function automatic int type_width(int n_types);
    return (n_types > 1) ? $clog2(n_types) : 1;
  endfunction
endpackage

// File: rtl/issue_prio_pick.sv
module issue_prio_pick
  import issue_pick_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] grant_o,
  output logic         any_o
);
  unit_vec_t wide_grant;

  always_comb begin
    wide_grant = lowest_set(unit_vec_t'(req_i));
    grant_o    = wide_grant[W-1:0];
    any_o      = |req_i;
  end

  // grant only to a requester, lowest wins
  p_grant_in_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_i) == '0);
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_grant_when_any_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> $countones(grant_o) == 1);
endmodule

// File: rtl/issue_type_group.sv
module issue_type_group #(
  parameter int                   NUM_UNITS = 6,
  parameter logic [NUM_UNITS-1:0] CAP_MASK  = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] busy_i,
  output logic [NUM_UNITS-1:0] pick_o,
  output logic                 avail_o
);
  logic [NUM_UNITS-1:0] cand;

  // busy units drop out of the candidate set
  assign cand = CAP_MASK & ~busy_i;

  issue_prio_pick #(.W(NUM_UNITS)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (cand),
    .grant_o(pick_o),
    .any_o  (avail_o)
  );

  p_pick_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_o & busy_i) == '0);
  p_pick_capable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_o & ~CAP_MASK) == '0);
endmodule

// File: rtl/issue_picker.sv
module issue_picker
  import issue_pick_pkg::*;
#(
  parameter int NUM_UNITS = 6,
  parameter int NUM_TYPES = 3,
  // bit t*NUM_UNITS+u set: unit u serves type t
  parameter logic [NUM_TYPES*NUM_UNITS-1:0] CAPS = 18'b110000_001100_000111,
  localparam int TYPE_W = type_width(NUM_TYPES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid_i,
  input  logic [TYPE_W-1:0]    in_type_i,
  output logic                 in_ready_o,
  output logic                 found_o,
  input  logic [NUM_UNITS-1:0] unit_busy_i,
  output logic [NUM_UNITS-1:0] issue_o,
  output logic [NUM_UNITS-1:0] selected_o
);
  logic [NUM_TYPES-1:0][NUM_UNITS-1:0] pick_all;
  logic [NUM_TYPES-1:0]                avail_all;
  logic [NUM_UNITS-1:0]                pick_sel;
  logic                                avail_sel;
  logic                                fire;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    issue_type_group #(
      .NUM_UNITS(NUM_UNITS),
      .CAP_MASK (CAPS[t*NUM_UNITS +: NUM_UNITS])
    ) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (unit_busy_i),
      .pick_o (pick_all[t]),
      .avail_o(avail_all[t])
    );
  end

  // route the requested type's picker; unknown codes find nothing
  always_comb begin
    pick_sel  = '0;
    avail_sel = 1'b0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      if (in_type_i == TYPE_W'(t)) begin
        pick_sel  = pick_all[t];
        avail_sel = avail_all[t];
      end
    end
  end

  assign found_o    = rst_n & avail_sel;
  assign in_ready_o = found_o;
  assign fire       = in_valid_i & found_o;
  assign issue_o    = fire ? pick_sel : '0;
  // grant spans the issue cycle plus the busy period that follows
  assign selected_o = issue_o | unit_busy_i;

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o == found_o);
  p_one_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && found_o) |-> $countones(issue_o) == 1);
  p_issue_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o & unit_busy_i) == '0);
  p_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |-> issue_o == '0);
  p_sel_covers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_o | unit_busy_i) & ~selected_o) == '0);

  always_comb begin
    if (!rst_n) begin
      p_quiet_in_reset_r8: assert (issue_o == '0 && !found_o);
    end
  end
endmodule

// File: tb/issue_picker_test.sv
module issue_picker_test;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_type = 2'd0;
  logic       in_ready, found;
  logic [N-1:0] busy = '0;
  logic [N-1:0] issue, selected;

  int checks = 0;
  int fails = 0;
  int dur = 3;
  int cnt [N];
  bit done = 0;

  always #4 clk = ~clk;

  issue_picker uut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_type_i(in_type),
    .in_ready_o(in_ready), .found_o(found), .unit_busy_i(busy),
    .issue_o(issue), .selected_o(selected)
  );

  function automatic bit capable(int t, int u);
    case (t)
      0: return u <= 2;
      1: return u == 2 || u == 3;
      2: return u >= 4;
      default: return 0;
    endcase
  endfunction

  // behavioural unit model: busy rises the cycle after issue
  initial for (int u = 0; u < N; u++) cnt[u] = 0;
  always @(posedge clk) begin
    for (int u = 0; u < N; u++) begin
      if (issue[u]) cnt[u] = dur;
      else if (cnt[u] > 0) cnt[u] = cnt[u] - 1;
      busy[u] <= (cnt[u] != 0);
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int first = -1;
    logic [N-1:0] exp_issue = '0;
    for (int u = 0; u < N; u++)
      if (first < 0 && capable(int'(in_type), u) && !busy[u]) first = u;
    if (in_valid && first >= 0) exp_issue[first] = 1'b1;
    chk(found == (first >= 0), "R1", "found", int'(found), int'(first >= 0));
    chk(in_ready == found, "R2", "ready", int'(in_ready), int'(found));
    chk($countones(issue) <= 1, "R3", "issue count", $countones(issue), 1);
    chk(issue == exp_issue, "R4", "issue", int'(issue), int'(exp_issue));
    chk((issue & busy) == '0, "R5", "issue to busy", int'(issue & busy), 0);
    chk(selected == (exp_issue | busy), "R6", "selected",
        int'(selected), int'(exp_issue | busy));
    if (!in_valid) chk(issue == '0, "R7", "issue w/o valid", int'(issue), 0);
  endtask

  task automatic step(bit v, int t);
    @(negedge clk);
    in_valid = v;
    in_type = 2'(t);
    #2 compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R8: quiet while reset held, even with a valid request
    @(negedge clk);
    in_valid = 1; in_type = 0;
    #2;
    chk(!found && !in_ready, "R8", "found in reset", int'(found), 0);
    chk(issue == '0, "R8", "issue in reset", int'(issue), 0);
    @(negedge clk);
    in_valid = 0;
    rst_n = 1;
    // long jobs: saturate type 0 then type 1 (shared unit 2)
    dur = 30;
    for (int i = 0; i < 5; i++) step(1, 0);
    for (int i = 0; i < 3; i++) step(1, 1);
    step(1, 3);               // R1: unmapped type finds nothing
    step(0, 2);               // R7: availability without valid
    for (int i = 0; i < 4; i++) step(1, 2);
    for (int i = 0; i < 32; i++) step(0, 0);
    // short jobs, mixed traffic
    for (int i = 0; i < 600; i++) begin
      dur = 1 + ($urandom % 5);
      step(($urandom % 4) != 0, $urandom % 4);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule